// File: doc/BRIEF.md
# Multi-Timer Count Snapshot Latch

This block sits between four free-running timer counters and the read data path of a register bank. Software never sees a counter directly. It sees holding registers that load the live counts when they are read, so a value cannot tear while a read is in flight. Timers 1 and 2 are 16 bits wide and share one 32-bit read word. Timers 3 and 4 each have their own 32-bit read word.

A mode input selects which reads trigger a capture. In per-register mode, each read refreshes only the timers that belong to the word being read. In group mode, only a read of the shared timer 1/2 word captures, and it loads all four timers on the same clock edge. Software can then read the timer 3 and timer 4 words afterwards and get values taken at the same instant as timers 1 and 2.

A read returns the freshly captured value in the strobe cycle itself: the live count passes straight through while the holding register loads it. The counters and the address decode that produces the strobes sit outside this block.

Top module: `tmr_snap_latch`

## Requirements
- R1: The shared word carries timer 2 in bits 31:16 and timer 1 in bits 15:0.
- R2: In the cycle a capture strobe is active, every word that captures shows the live counts of that cycle.
- R3: With mode 0, a read of the timer 1/2 word captures timers 1 and 2 together and leaves the timer 3 and timer 4 words unchanged.
- R4: With mode 0, a read of the timer 3 word captures timer 3 only, and a read of the timer 4 word captures timer 4 only.
- R5: With mode 1, a read of the timer 1/2 word captures all four timers on the same clock edge.
- R6: With mode 1, reads of the timer 3 or timer 4 word do not capture; they return the value held from the last group capture.
- R7: With no capturing strobe, every read word holds its value while the live counts change.
- R8: After reset, all held values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Capture mode: 0 = per register, 1 = group on the timer 1/2 read |
| rd12_i | input | 1 | Read strobe for the timer 1/2 word |
| rd3_i | input | 1 | Read strobe for the timer 3 word |
| rd4_i | input | 1 | Read strobe for the timer 4 word |
| cnt1_i | input | 16 | Live count of timer 1 |
| cnt2_i | input | 16 | Live count of timer 2 |
| cnt3_i | input | 32 | Live count of timer 3 |
| cnt4_i | input | 32 | Live count of timer 4 |
| rd12_o | output | 32 | Read data for the timer 1/2 word |
| rd3_o | output | 32 | Read data for the timer 3 word |
| rd4_o | output | 32 | Read data for the timer 4 word |

## Verification
The properties assume that each read strobe lasts one cycle per access and that the mode input is stable across a group capture and the reads that follow it. The snapshot properties compare the outputs with the counts of the previous cycle only when the mode is the same in both cycles. The bench changes the mode only on cycles with no strobe active. It loads new random live counts every cycle, so a word that recaptures when it should hold shows up as a mismatch.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic {
    SNAP_PER_REG = 1'b0,
    SNAP_GROUP   = 1'b1
  } snap_mode_e;

  localparam int unsigned NUM_TMR = 4;
  localparam int unsigned NUM_RD  = 3;
  localparam int unsigned RD_12   = 0;
  localparam int unsigned RD_3    = 1;
  localparam int unsigned RD_4    = 2;
endpackage

// File: rtl/tsl_ctrl.sv
module tsl_ctrl
  import tsl_pkg::*;
(
  input  logic               mode_i,
  input  logic [NUM_RD-1:0]  rd_i,
  output logic [NUM_TMR-1:0] cap_o
);
  logic grp;

  always_comb begin
    grp      = (snap_mode_e'(mode_i) == SNAP_GROUP);
    cap_o[0] = rd_i[RD_12];
    cap_o[1] = rd_i[RD_12];
    // group mode: only the shared word read captures, and it takes all four
    cap_o[2] = grp ? rd_i[RD_12] : rd_i[RD_3];
    cap_o[3] = grp ? rd_i[RD_12] : rd_i[RD_4];
  end
endmodule

// File: rtl/tsl_slot.sv
module tsl_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] view_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_q <= '0;
    else if (cap_i) held_q <= live_i;
  end

  // the read that captures returns the value being captured
  assign view_o = cap_i ? live_i : held_q;
endmodule

// File: rtl/tmr_snap_latch.sv
module tmr_snap_latch
  import tsl_pkg::*;
#(
  parameter int unsigned T12_W = 16,
  parameter int unsigned T34_W = 32,
  localparam int unsigned W12  = 2 * T12_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             rd12_i,
  input  logic             rd3_i,
  input  logic             rd4_i,
  input  logic [T12_W-1:0] cnt1_i,
  input  logic [T12_W-1:0] cnt2_i,
  input  logic [T34_W-1:0] cnt3_i,
  input  logic [T34_W-1:0] cnt4_i,
  output logic [W12-1:0]   rd12_o,
  output logic [T34_W-1:0] rd3_o,
  output logic [T34_W-1:0] rd4_o
);
  logic [NUM_RD-1:0]  rd;
  logic [NUM_TMR-1:0] cap;
  logic [T12_W-1:0]   lo_live [2];
  logic [T12_W-1:0]   lo_view [2];
  logic [T34_W-1:0]   hi_live [2];
  logic [T34_W-1:0]   hi_view [2];

  always_comb begin
    rd         = '0;
    rd[RD_12]  = rd12_i;
    rd[RD_3]   = rd3_i;
    rd[RD_4]   = rd4_i;
    lo_live[0] = cnt1_i;
    lo_live[1] = cnt2_i;
    hi_live[0] = cnt3_i;
    hi_live[1] = cnt4_i;
  end

  tsl_ctrl u_ctrl (
    .mode_i (mode_i),
    .rd_i   (rd),
    .cap_o  (cap)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lo
    tsl_slot #(.W(T12_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap[g]),
      .live_i (lo_live[g]),
      .view_o (lo_view[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_hi
    tsl_slot #(.W(T34_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap[g+2]),
      .live_i (hi_live[g]),
      .view_o (hi_view[g])
    );
  end

  assign rd12_o = {lo_view[1], lo_view[0]};
  assign rd3_o  = hi_view[0];
  assign rd4_o  = hi_view[1];
endmodule

// File: rtl/tsl_chk.sv
module tsl_chk #(
  parameter int unsigned T12_W = 16,
  parameter int unsigned T34_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_i,
  input logic               rd12_i,
  input logic               rd3_i,
  input logic               rd4_i,
  input logic [T12_W-1:0]   cnt1_i,
  input logic [T12_W-1:0]   cnt2_i,
  input logic [T34_W-1:0]   cnt3_i,
  input logic [T34_W-1:0]   cnt4_i,
  input logic [2*T12_W-1:0] rd12_o,
  input logic [T34_W-1:0]   rd3_o,
  input logic [T34_W-1:0]   rd4_o
);
  logic ld3, ld4;
  assign ld3 = mode_i ? rd12_i : rd3_i;
  assign ld4 = mode_i ? rd12_i : rd4_i;

  p_pack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd12_i |-> rd12_o == {cnt2_i, cnt1_i});

  p_group_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && rd12_i) |-> (rd3_o == cnt3_i && rd4_o == cnt4_i));

  p_hold12_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd12_i ##1 !rd12_i) |-> $stable(rd12_o));

  p_own3_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && rd3_i) ##1 (!mode_i && !rd3_i) |-> rd3_o == $past(cnt3_i));

  p_snap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && rd12_i) ##1 (mode_i && !rd12_i) |->
      (rd3_o == $past(cnt3_i) && rd4_o == $past(cnt4_i)));

  p_no_relatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !rd12_i) ##1 (mode_i && !rd12_i) |->
      ($stable(rd3_o) && $stable(rd4_o)));

  p_hold3_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld3 ##1 !ld3) |-> $stable(rd3_o));

  p_hold4_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld4 ##1 !ld4) |-> $stable(rd4_o));
endmodule

bind tmr_snap_latch tsl_chk #(.T12_W(T12_W), .T34_W(T34_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .rd12_i (rd12_i),
  .rd3_i  (rd3_i),
  .rd4_i  (rd4_i),
  .cnt1_i (cnt1_i),
  .cnt2_i (cnt2_i),
  .cnt3_i (cnt3_i),
  .cnt4_i (cnt4_i),
  .rd12_o (rd12_o),
  .rd3_o  (rd3_o),
  .rd4_o  (rd4_o)
);

// File: tb/tb_tmr_snap_latch.sv
module tb_tmr_snap_latch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, r12 = 1'b0, r3 = 1'b0, r4 = 1'b0;
  logic [15:0] c1 = '0, c2 = '0;
  logic [31:0] c3 = '0, c4 = '0;
  logic [31:0] o12, o3, o4;

  always #(CLK_P/2) clk = ~clk;

  tmr_snap_latch dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .rd12_i(r12), .rd3_i(r3), .rd4_i(r4),
    .cnt1_i(c1), .cnt2_i(c2), .cnt3_i(c3), .cnt4_i(c4),
    .rd12_o(o12), .rd3_o(o3), .rd4_o(o4)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  event drv_ev;

  logic [15:0] h1 = '0, h2 = '0;
  logic [31:0] h3 = '0, h4 = '0;

  task automatic step(string tag, bit m, bit s12, bit s3, bit s4);
    bit k3, k4;
    item_t it;
    @(negedge clk);
    mode = m; r12 = s12; r3 = s3; r4 = s4;
    c1 = 16'($urandom); c2 = 16'($urandom);
    c3 = $urandom; c4 = $urandom;
    k3 = m ? s12 : s3;
    k4 = m ? s12 : s4;
    it.tag = tag;
    it.sel = 0; it.exp = s12 ? {c2, c1} : {h2, h1}; q.push_back(it);
    it.sel = 1; it.exp = k3 ? c3 : h3; q.push_back(it);
    it.sel = 2; it.exp = k4 ? c4 : h4; q.push_back(it);
    if (s12) begin h1 = c1; h2 = c2; end
    if (k3) h3 = c3;
    if (k4) h4 = c4;
    -> drv_ev;
  endtask

  initial begin
    forever begin
      @(drv_ev);
      #(CLK_P/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.sel == 0) ? o12 : (it.sel == 1) ? o3 : o4;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s word%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R8 reset values zero", 0, 0, 0, 0);
    step("R1 shared word packing", 0, 1, 0, 0);
    step("R1 shared word packing", 0, 1, 0, 0);
    step("R7 hold idle", 0, 0, 0, 0);
    step("R7 hold idle", 0, 0, 0, 0);
    step("R4 mode0 timer3 only", 0, 0, 1, 0);
    step("R4 mode0 timer4 only", 0, 0, 0, 1);
    step("R3 mode0 shared word leaves 3/4", 0, 1, 0, 0);
    step("R7 hold idle", 0, 0, 0, 0);
    step("R2 mode0 all strobes", 0, 1, 1, 1);
    step("R7 hold idle", 0, 0, 0, 0);
    step("R7 mode switch idle", 1, 0, 0, 0);
    step("R5 mode1 group capture", 1, 1, 0, 0);
    step("R6 mode1 timer3 read no relatch", 1, 0, 1, 0);
    step("R6 mode1 timer4 read no relatch", 1, 0, 0, 1);
    step("R6 mode1 both reads no relatch", 1, 0, 1, 1);
    step("R7 hold idle mode1", 1, 0, 0, 0);
    step("R5 mode1 group with timer3 read", 1, 1, 1, 0);
    step("R6 mode1 reads after group", 1, 0, 1, 1);
    step("R7 mode switch idle", 0, 0, 0, 0);
    step("R4 mode0 timer3 after group", 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      bit m;
      m = (i / 10) % 2 == 1;
      if (i % 10 == 0) step("R7 mode switch idle", m, 0, 0, 0);
      else step("R2 mixed strobes", m, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    #(CLK_P);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule